// File: doc/BRIEF.md
# Isochronous IN Endpoint Transmitter

This block is the transmit half of a USB device endpoint that serves isochronous IN transfers. A processor or a DMA engine loads packet bytes one at a time through a small register write port into a two-slot packet store. A packet is closed either when it reaches the 256-byte payload limit or when the writer sets the short-packet bit. The endpoint then sends the oldest released packet, one byte per cycle, when the serial side presents an IN token. Isochronous endpoints never refuse a token. If nothing has been released when the token arrives, the block answers with a zero-length packet and records an underrun.

Software can work in three ways. It can hand each packet over by clearing the packet-complete bit and then service the endpoint interrupt. It can let a DMA engine keep the store filled, which releases each packet as soon as it is closed. It can also poll the FIFO-service bit from a start-of-frame handler. The endpoint interrupt and the start-of-frame interrupt each have their own mask. A masked event is still recorded in its status bit.

Top module: `iso_in_ep`

## Requirements
- R1: After a synchronous reset the status register reads 0x05, so packet-complete (bit 0) and FIFO-service (bit 2) are 1 and all other bits are 0. The control register reads 0x03: endpoint mask (bit 0) and SOF mask (bit 1) are 1 and DMA enable (bit 2) is 0. The SOF status reads 0, and tx_valid, tx_zlp, ep_irq, sof_irq and dma_req are all 0.
- R2: A packet that reaches 256 data writes (address 0) is closed without a short flag. Once released, an IN token makes tx_valid rise in the cycle after the token is sampled. The 256 bytes then follow in write order, one per cycle, and tx_last is high on the final byte only.
- R3: Writing 1 to status bit 1 (short) closes the packet being filled with exactly the bytes written so far. A released zero-byte packet is sent as a one-cycle tx_zlp pulse with no tx_valid and no underrun.
- R4: Writing 1 to status bit 0 releases every closed packet and clears packet-complete. A closed packet that has not been released is not sent. Every answer to an IN token sets packet-complete again once the answer ends.
- R5: An IN token that finds no released packet produces a one-cycle tx_zlp pulse in the next cycle and no tx_valid, and sets underrun (status bit 3). Underrun is cleared by writing 1 to it.
- R6: Each packet sent sets the endpoint status bit (status bit 4). ep_irq equals that bit while the endpoint mask is 0 and is 0 while the mask is 1. Writing 1 clears the bit, and a completion in the same cycle as that write leaves it set.
- R7: FIFO-service (status bit 2) is 1 while at least one of the two slots is not closed. While both are closed, data writes are ignored.
- R8: Two closed packets are sent in the order they were closed, on two successive IN tokens.
- R9: Each sof strobe sets the SOF status bit (address 3, bit 0). sof_irq equals that bit while the SOF mask is 0. Writing 1 clears the bit, and a strobe in the same cycle as that write leaves it set.
- R10: While DMA enable is 1, closing a packet also releases it, and dma_req is high exactly while DMA enable and FIFO-service are both 1.
- R11: A bus_rst strobe discards both slots and any transfer in progress. It sets packet-complete and FIFO-service and clears underrun, endpoint status and SOF status. The mask and DMA enable bits keep their values.
- R12: An IN token that arrives while a packet is being sent is ignored. It neither shortens the packet nor produces a later zero-length answer or underrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_rst | input | 1 | USB bus reset strobe, one cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 status, 2 control, 3 SOF status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Read data, combinational |
| in_tok | input | 1 | IN token strobe from the token decoder |
| sof | input | 1 | Start-of-frame strobe |
| tx_valid | output | 1 | Packet byte present on tx_data |
| tx_data | output | 8 | Packet byte to the transmitter |
| tx_last | output | 1 | Final byte of the packet |
| tx_zlp | output | 1 | Send a zero-length data packet |
| ep_irq | output | 1 | Endpoint interrupt |
| sof_irq | output | 1 | Start-of-frame interrupt |
| dma_req | output | 1 | Request for more packet data from DMA |

## Verification
Two status bits can be set by the hardware and cleared by software in the same cycle. The SOF status bit is hit by a sof strobe and a write-1-to-clear of address 3 on one edge. The endpoint status bit is hit by the cycle that carries tx_last, during which the bench issues the clear of status bit 4. In both cases the bench reads the bit back afterwards and expects it still set, because a lost event would hide a frame or a packet from software. The bench also expects the matching interrupt to stay asserted while its mask is 0.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;

  typedef enum logic [1:0] {
    ADR_DATA = 2'd0,
    ADR_STAT = 2'd1,
    ADR_CTRL = 2'd2,
    ADR_SOF  = 2'd3
  } reg_adr_e;

  // status register bit positions
  localparam int unsigned ST_DONE  = 0;
  localparam int unsigned ST_SHORT = 1;
  localparam int unsigned ST_ROOM  = 2;
  localparam int unsigned ST_UNDR  = 3;
  localparam int unsigned ST_EPEV  = 4;

  // control register bit positions
  localparam int unsigned CT_EPMSK  = 0;
  localparam int unsigned CT_SOFMSK = 1;
  localparam int unsigned CT_DMA    = 2;

  // the byte just accepted brings the slot to its limit
  function automatic bit fills_slot(int unsigned count_before, int unsigned limit);
    return (count_before + 1) == limit;
  endfunction

  // the byte at index idx is the final byte of a packet of length len
  function automatic bit final_byte(int unsigned idx, int unsigned len);
    return (idx + 1) == len;
  endfunction

endpackage

// File: rtl/iso_in_buf.sv
module iso_in_buf #(
  parameter int unsigned MAX_PKT = 256,
  parameter int unsigned DW      = 8,
  localparam int unsigned CW     = $clog2(MAX_PKT + 1),
  localparam int unsigned IW     = $clog2(MAX_PKT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          seal,
  input  logic          arm_all,
  input  logic          arm_on_seal,
  input  logic          pop,
  input  logic [IW-1:0] rd_idx,
  output logic          head_armed,
  output logic [CW-1:0] head_len,
  output logic [DW-1:0] rd_byte,
  output logic          room
);
  localparam int unsigned NSLOT = 2;

  logic [DW-1:0] mem [NSLOT][MAX_PKT];
  logic [NSLOT-1:0] closed_q, closed_n;
  logic [NSLOT-1:0] armed_q, armed_n;
  logic [CW-1:0]    cnt_q [NSLOT];
  logic [CW-1:0]    cnt_n [NSLOT];
  logic             wp_q, hp_q;

  logic push_ok, seal_full, seal_now;

  assign push_ok   = push && !closed_q[wp_q];
  assign seal_full = push_ok && iso_in_pkg::fills_slot(int'(cnt_q[wp_q]), MAX_PKT);
  assign seal_now  = seal_full || (seal && !closed_q[wp_q]);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic is_w, is_h, pop_s, seal_s;
    assign is_w   = (wp_q == 1'(s));
    assign is_h   = (hp_q == 1'(s));
    assign pop_s  = pop && is_h;
    assign seal_s = seal_now && is_w;
    assign closed_n[s] = pop_s ? 1'b0 : (closed_q[s] || seal_s);
    assign armed_n[s]  = pop_s ? 1'b0 :
                         (armed_q[s] || (seal_s && arm_on_seal) || (arm_all && closed_n[s]));
    assign cnt_n[s]    = pop_s ? '0 :
                         (push_ok && is_w) ? cnt_q[s] + 1'b1 : cnt_q[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      closed_q <= '0;
      armed_q  <= '0;
      wp_q     <= 1'b0;
      hp_q     <= 1'b0;
      for (int s = 0; s < NSLOT; s++) cnt_q[s] <= '0;
    end else begin
      closed_q <= closed_n;
      armed_q  <= armed_n;
      wp_q     <= seal_now ? ~wp_q : wp_q;
      hp_q     <= pop ? ~hp_q : hp_q;
      for (int s = 0; s < NSLOT; s++) cnt_q[s] <= cnt_n[s];
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q][cnt_q[wp_q][IW-1:0]] <= push_data;
  end

  assign head_armed = armed_q[hp_q];
  assign head_len   = cnt_q[hp_q];
  assign rd_byte    = mem[hp_q][rd_idx];
  assign room       = !(&closed_q);

endmodule

// File: rtl/iso_in_tx.sv
module iso_in_tx #(
  parameter int unsigned MAX_PKT = 256,
  localparam int unsigned CW     = $clog2(MAX_PKT + 1),
  localparam int unsigned IW     = $clog2(MAX_PKT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tok,
  input  logic          head_armed,
  input  logic [CW-1:0] head_len,
  output logic          busy,
  output logic [IW-1:0] idx,
  output logic          last,
  output logic          zlp,
  output logic          pop,
  output logic          underrun_ev,
  output logic          answered
);
  logic          busy_q, zlp_q;
  logic [IW-1:0] idx_q;
  logic          start, empty_pkt, go_data, go_zlp;

  assign start     = tok && !busy_q;
  assign empty_pkt = (head_len == '0);
  assign go_data   = start && head_armed && !empty_pkt;
  assign go_zlp    = start && (!head_armed || empty_pkt);

  assign last        = busy_q && iso_in_pkg::final_byte(int'(idx_q), int'(head_len));
  assign pop         = last || (start && head_armed && empty_pkt);
  assign underrun_ev = start && !head_armed;
  assign answered    = last || go_zlp;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      zlp_q  <= 1'b0;
    end else begin
      zlp_q <= go_zlp;
      if (go_data) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (busy_q) begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
  assign zlp  = zlp_q;

endmodule

// File: rtl/iso_in_regs.sv
module iso_in_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       room,
  input  logic       answered,
  input  logic       pkt_sent,
  input  logic       underrun_ev,
  input  logic       sof,
  output logic       push,
  output logic       seal,
  output logic       arm_all,
  output logic       dma_en,
  output logic       done_bit,
  output logic       ep_sts,
  output logic       undr_bit,
  output logic       sof_sts,
  output logic       ep_irq,
  output logic       sof_irq
);
  import iso_in_pkg::*;

  logic ep_msk_q, sof_msk_q, dma_q;
  logic done_q, ep_q, undr_q, sof_q;
  logic wr_stat, wr_ctrl, wr_sof;

  assign wr_stat = wr_en && (wr_addr == ADR_STAT);
  assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
  assign wr_sof  = wr_en && (wr_addr == ADR_SOF);

  assign push    = wr_en && (wr_addr == ADR_DATA);
  assign seal    = wr_stat && wr_data[ST_SHORT];
  assign arm_all = wr_stat && wr_data[ST_DONE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_msk_q  <= 1'b1;
      sof_msk_q <= 1'b1;
      dma_q     <= 1'b0;
    end else if (wr_ctrl) begin
      ep_msk_q  <= wr_data[CT_EPMSK];
      sof_msk_q <= wr_data[CT_SOFMSK];
      dma_q     <= wr_data[CT_DMA];
    end
  end

  // hardware set wins over a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      done_q <= 1'b1;
      ep_q   <= 1'b0;
      undr_q <= 1'b0;
      sof_q  <= 1'b0;
    end else begin
      if (answered)                         done_q <= 1'b1;
      else if (arm_all)                     done_q <= 1'b0;
      if (pkt_sent)                         ep_q   <= 1'b1;
      else if (wr_stat && wr_data[ST_EPEV]) ep_q   <= 1'b0;
      if (underrun_ev)                      undr_q <= 1'b1;
      else if (wr_stat && wr_data[ST_UNDR]) undr_q <= 1'b0;
      if (sof)                              sof_q  <= 1'b1;
      else if (wr_sof && wr_data[0])        sof_q  <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_STAT: begin
        rd_data[ST_DONE] = done_q;
        rd_data[ST_ROOM] = room;
        rd_data[ST_UNDR] = undr_q;
        rd_data[ST_EPEV] = ep_q;
      end
      ADR_CTRL: begin
        rd_data[CT_EPMSK]  = ep_msk_q;
        rd_data[CT_SOFMSK] = sof_msk_q;
        rd_data[CT_DMA]    = dma_q;
      end
      ADR_SOF:  rd_data[0] = sof_q;
      default:  rd_data = '0;
    endcase
  end

  assign dma_en   = dma_q;
  assign done_bit = done_q;
  assign ep_sts   = ep_q;
  assign undr_bit = undr_q;
  assign sof_sts  = sof_q;
  assign ep_irq   = ep_q && !ep_msk_q;
  assign sof_irq  = sof_q && !sof_msk_q;

endmodule

// File: rtl/iso_in_ep.sv
module iso_in_ep #(
  parameter int unsigned MAX_PKT = 256,
  localparam int unsigned CW     = $clog2(MAX_PKT + 1),
  localparam int unsigned IW     = $clog2(MAX_PKT)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       in_tok,
  input  logic       sof,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last,
  output logic       tx_zlp,
  output logic       ep_irq,
  output logic       sof_irq,
  output logic       dma_req
);
  // named internal events, also observed by the bound checker
  logic          push_w, seal_w, arm_all_w, dma_en_w;
  logic          head_armed_w, room_w;
  logic [CW-1:0] head_len_w;
  logic [IW-1:0] rd_idx_w;
  logic          pkt_sent_w, underrun_w, answered_w;
  logic          tpc_w, ep_sts_w, undr_bit_w, sof_sts_w;

  iso_in_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (bus_rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .room        (room_w),
    .answered    (answered_w),
    .pkt_sent    (pkt_sent_w),
    .underrun_ev (underrun_w),
    .sof         (sof),
    .push        (push_w),
    .seal        (seal_w),
    .arm_all     (arm_all_w),
    .dma_en      (dma_en_w),
    .done_bit    (tpc_w),
    .ep_sts      (ep_sts_w),
    .undr_bit    (undr_bit_w),
    .sof_sts     (sof_sts_w),
    .ep_irq      (ep_irq),
    .sof_irq     (sof_irq)
  );

  iso_in_buf #(.MAX_PKT(MAX_PKT), .DW(8)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (bus_rst),
    .push        (push_w),
    .push_data   (wr_data),
    .seal        (seal_w),
    .arm_all     (arm_all_w),
    .arm_on_seal (dma_en_w),
    .pop         (pkt_sent_w),
    .rd_idx      (rd_idx_w),
    .head_armed  (head_armed_w),
    .head_len    (head_len_w),
    .rd_byte     (tx_data),
    .room        (room_w)
  );

  iso_in_tx #(.MAX_PKT(MAX_PKT)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (bus_rst),
    .tok         (in_tok),
    .head_armed  (head_armed_w),
    .head_len    (head_len_w),
    .busy        (tx_valid),
    .idx         (rd_idx_w),
    .last        (tx_last),
    .zlp         (tx_zlp),
    .pop         (pkt_sent_w),
    .underrun_ev (underrun_w),
    .answered    (answered_w)
  );

  assign dma_req = dma_en_w && room_w;

endmodule

// File: rtl/iso_in_ep_chk.sv
module iso_in_ep_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_rst,
  input logic sof,
  input logic tx_valid,
  input logic tx_last,
  input logic tx_zlp,
  input logic dma_req,
  input logic pkt_sent,
  input logic tpc,
  input logic ep_sts,
  input logic sof_sts,
  input logic room
);

  p_last_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  p_zlp_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zlp |-> !tx_valid);

  p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && !bus_rst) |=> tpc);

  p_sent_sets_ev_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && !bus_rst) |=> ep_sts);

  p_sof_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !bus_rst) |=> sof_sts);

  p_no_req_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !room |-> !dma_req);

  p_bus_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (room && tpc && !ep_sts && !tx_valid));

  p_no_cut_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_valid) && !$past(bus_rst)) |-> $past(tx_last));

endmodule

bind iso_in_ep iso_in_ep_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_rst  (bus_rst),
  .sof      (sof),
  .tx_valid (tx_valid),
  .tx_last  (tx_last),
  .tx_zlp   (tx_zlp),
  .dma_req  (dma_req),
  .pkt_sent (pkt_sent_w),
  .tpc      (tpc_w),
  .ep_sts   (ep_sts_w),
  .sof_sts  (sof_sts_w),
  .room     (room_w)
);

// File: tb/iso_in_ep_bench.sv
module iso_in_ep_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       in_tok = 1'b0;
  logic       sof = 1'b0;
  logic       tx_valid, tx_last, tx_zlp, ep_irq, sof_irq, dma_req;
  logic [7:0] tx_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  iso_in_ep u_iso_in_ep (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .in_tok(in_tok), .sof(sof),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp),
    .ep_irq(ep_irq), .sof_irq(sof_irq), .dma_req(dma_req)
  );

  // {seed[16:9], length[8:0]}
  localparam logic [16:0] VEC [6] = '{
    {8'h10, 9'd1}, {8'h22, 9'd2}, {8'h5A, 9'd37},
    {8'h01, 9'd255}, {8'hC3, 9'd256}, {8'h77, 9'd0}
  };

  function automatic logic [7:0] pat(logic [7:0] seed, int i);
    return seed + 8'(i * 3);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic load(logic [7:0] seed, int len);
    for (int i = 0; i < len; i++) wr(2'd0, pat(seed, i));
  endtask

  task automatic run_token(logic [7:0] seed, int extra_at,
                           output int n, output int bad, output int last_at, output int zlp);
    n = 0; bad = 0; last_at = -1;
    @(negedge clk); in_tok = 1'b1;
    @(negedge clk); in_tok = 1'b0;
    zlp = int'(tx_zlp);
    for (int g = 0; g < 300 && tx_valid; g++) begin
      if (tx_data !== pat(seed, n)) bad++;
      if (tx_last) last_at = n;
      n++;
      in_tok = (n == extra_at);
      @(negedge clk);
    end
    in_tok = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int v, n, bad, lst, z, len;
    logic [7:0] seed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, v); chk("R1 status", v, 8'h05);
    rd(2'd2, v); chk("R1 control", v, 8'h03);
    rd(2'd3, v); chk("R1 sof status", v, 0);
    chk("R1 outputs", int'({tx_valid, tx_zlp, ep_irq, sof_irq, dma_req}), 0);

    // R2 / R3 vector table: full and short packets
    for (int k = 0; k < 6; k++) begin
      seed = VEC[k][16:9];
      len  = int'(VEC[k][8:0]);
      load(seed, len);
      wr(2'd1, (len < 256) ? 8'h03 : 8'h01);
      run_token(seed, -1, n, bad, lst, z);
      chk("R2/R3 byte count", n, len);
      chk("R2/R3 byte values", bad, 0);
      chk("R2 last position", lst, (len == 0) ? -1 : len - 1);
      chk("R3 zero-length pulse", z, (len == 0) ? 1 : 0);
      rd(2'd1, v); chk("R4/R6 status after send", v & 8'h19, 8'h11);
      wr(2'd1, 8'h10);
    end

    // R5 underrun with nothing loaded
    run_token(8'h00, -1, n, bad, lst, z);
    chk("R5 no data", n, 0);
    chk("R5 zlp", z, 1);
    rd(2'd1, v); chk("R5 underrun set", (v >> 3) & 1, 1);
    wr(2'd1, 8'h08);
    rd(2'd1, v); chk("R5 underrun cleared", (v >> 3) & 1, 0);

    // R4 closed but not released packet is withheld
    load(8'hA0, 5);
    wr(2'd1, 8'h02);
    rd(2'd1, v); chk("R4 done still set", v & 1, 1);
    run_token(8'hA0, -1, n, bad, lst, z);
    chk("R4 withheld count", n, 0);
    chk("R4 withheld zlp", z, 1);
    wr(2'd1, 8'h08);
    wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R4 done cleared", v & 1, 0);
    run_token(8'hA0, -1, n, bad, lst, z);
    chk("R4 released count", n, 5);
    chk("R4 released data", bad, 0);
    rd(2'd1, v); chk("R4 done set again", v & 1, 1);

    // R7 / R8 two slots, ordering, write ignored while full
    load(8'h30, 10);
    wr(2'd1, 8'h02);
    load(8'h40, 256);
    rd(2'd1, v); chk("R7 no room", (v >> 2) & 1, 0);
    wr(2'd0, 8'hEE);
    wr(2'd1, 8'h01);
    run_token(8'h30, -1, n, bad, lst, z);
    chk("R8 first packet count", n, 10);
    chk("R8 first packet data", bad, 0);
    rd(2'd1, v); chk("R7 room again", (v >> 2) & 1, 1);
    run_token(8'h40, -1, n, bad, lst, z);
    chk("R8 second packet count", n, 256);
    chk("R7 R8 second packet data", bad, 0);

    // R12 token during transmission
    wr(2'd1, 8'h18);
    load(8'h55, 20);
    wr(2'd1, 8'h03);
    run_token(8'h55, 5, n, bad, lst, z);
    chk("R12 count", n, 20);
    chk("R12 data", bad, 0);
    @(negedge clk);
    chk("R12 no late answer", int'({tx_valid, tx_zlp}), 0);
    rd(2'd1, v); chk("R12 no underrun", (v >> 3) & 1, 0);

    // R6 mask and set-wins collision
    chk("R6 masked irq", int'(ep_irq), 0);
    rd(2'd1, v); chk("R6 masked event recorded", (v >> 4) & 1, 1);
    wr(2'd2, 8'h02);
    chk("R6 unmasked irq", int'(ep_irq), 1);
    wr(2'd1, 8'h10);
    chk("R6 cleared irq", int'(ep_irq), 0);
    load(8'h09, 1);
    wr(2'd1, 8'h03);
    @(negedge clk); in_tok = 1'b1;
    @(negedge clk); in_tok = 1'b0;
    chk("R6 last present", int'(tx_last), 1);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h10;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd1, v); chk("R6 set wins over clear", (v >> 4) & 1, 1);
    chk("R6 irq kept", int'(ep_irq), 1);
    wr(2'd1, 8'h10);

    // R9 SOF status and interrupt
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    rd(2'd3, v); chk("R9 sof status", v, 1);
    chk("R9 masked sof irq", int'(sof_irq), 0);
    wr(2'd2, 8'h00);
    chk("R9 sof irq", int'(sof_irq), 1);
    @(negedge clk); sof = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
    @(negedge clk); sof = 1'b0; wr_en = 1'b0;
    rd(2'd3, v); chk("R9 set wins over clear", v, 1);
    wr(2'd3, 8'h01);
    rd(2'd3, v); chk("R9 cleared", v, 0);
    chk("R9 irq dropped", int'(sof_irq), 0);

    // R10 DMA path
    wr(2'd2, 8'h04);
    chk("R10 request", int'(dma_req), 1);
    load(8'h66, 3);
    wr(2'd1, 8'h02);
    run_token(8'h66, -1, n, bad, lst, z);
    chk("R10 auto release count", n, 3);
    chk("R10 auto release data", bad, 0);
    load(8'h70, 4); wr(2'd1, 8'h02);
    load(8'h80, 4); wr(2'd1, 8'h02);
    chk("R10 request dropped when full", int'(dma_req), 0);
    run_token(8'h70, -1, n, bad, lst, z);
    chk("R10 request back", int'(dma_req), 1);
    run_token(8'h80, -1, n, bad, lst, z);
    chk("R10 second auto packet", n, 4);

    // R11 bus reset
    wr(2'd2, 8'h03);
    load(8'h90, 7);
    wr(2'd1, 8'h02);
    run_token(8'h90, -1, n, bad, lst, z);
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0; bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    rd(2'd1, v); chk("R11 status", v, 8'h05);
    rd(2'd3, v); chk("R11 sof status", v, 0);
    rd(2'd2, v); chk("R11 control kept", v, 8'h03);
    wr(2'd1, 8'h01);
    run_token(8'h90, -1, n, bad, lst, z);
    chk("R11 slot discarded", n, 0);
    chk("R11 zlp after discard", z, 1);

    finish_run();
  end

endmodule